// File: doc/BRIEF.md
# Flash Erase-Block Select Register

This block is the control point for choosing which flash block an erase operation may act on. Software writes through a small register bus into two erase-select registers: a low one for the eight small blocks and a high one for the four large blocks. It also writes a RAM-overlay control register. The block shows the current choice as a twelve-bit one-hot vector, together with the first and last byte address of the chosen block. It raises an erase-enable flag only when every protection condition allows it.

Three rules guard the selection. A write that would leave two or more select bits set across both registers wipes the whole selection. A high level on the hardware protect pin, or a software write-enable of 0, holds both select registers at zero. Setting the overlay bit marks all of flash as protected against program and erase. The erase sequencing, the flash timing and the overlay address remapping are outside this block.

Top module: `flash_eblk_sel`

## Requirements
- R1: A synchronous active-high reset clears both select registers and the overlay register, so every readable register returns 0.
- R2: Offset 0 holds the low select register, where bit k (0..7) selects block k. Offset 1 holds the high select register, where bits 3..0 select blocks 11..8 (bit j selects block 8+j). Bits 7..4 of offset 1 read as 0, and data written to them is dropped.
- R3: While `wp_pin` is 1, both select registers are held at 0 from the next clock edge onward, and writes to them are ignored.
- R4: While `sw_en` is 0, both select registers are held at 0 whatever level `wp_pin` has, and writes to them are ignored.
- R5: If a write would leave more than one select bit set across both select registers, both registers read 0 after that clock edge. Read-back never shows two select bits set.
- R6: Offset 2 is the overlay register. Bit 0 is the overlay-enable bit, and bits 15..1 read as 0. `pe_protect` equals the stored overlay bit. The overlay bit is not affected by `wp_pin` or `sw_en`.
- R7: `erase_en` is 1 only when exactly one select bit is set, `sw_en` is 1, `wp_pin` is 0 and the overlay bit is 0.
- R8: Blocks 0..7 are 4 KB each, starting at k*0x1000. Block 8 spans 0x008000..0x00FFFF. Blocks 9, 10 and 11 are 64 KB each, starting at 0x010000, 0x020000 and 0x030000. `blk_start` and `blk_end` give the first and last byte of the selected block.
- R9: When no single block is selected, `blk_start` and `blk_end` are both 0.
- R10: A read at offset 3 returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 2 | Register offset |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| wp_pin | input | 1 | Hardware write-protect, active high |
| sw_en | input | 1 | Software program/erase enable |
| blk_sel | output | 12 | One-hot block selection, bit n is block n |
| blk_start | output | 18 | First byte address of the selected block |
| blk_end | output | 18 | Last byte address of the selected block |
| pe_protect | output | 1 | Global program/erase protect from the overlay bit |
| erase_en | output | 1 | Erase is permitted on the selected block |

## Verification
The bench targets writes that complete a second select bit through the *other* register. A design that checks only the register being written would then keep a two-hot selection. It also writes with `wp_pin` low but `sw_en` 0, which catches a design that honours only the pin. Other stimulus writes ones into the reserved high bits, which a careless mask would store, and selects block 8, whose half-size range is the likeliest place for an off-by-one in the address map. A random mix of single-bit, multi-bit and protected writes is then compared against a bench model on every cycle.

// File: rtl/feb_pkg.sv
package feb_pkg;
    localparam int LO_W     = 8;
    localparam int HI_W     = 4;
    localparam int NUM_BLK  = LO_W + HI_W;
    localparam int ADDR_W   = 18;
    localparam int DATA_W   = 16;
    localparam int OFS_W    = 2;
    localparam int SMALL_SZ = 'h1000;
    localparam int MID_BASE = 'h8000;
    localparam int BIG_SZ   = 'h10000;

    typedef enum logic [OFS_W-1:0] {
        OFS_EB_LO = 2'd0,
        OFS_EB_HI = 2'd1,
        OFS_OVL   = 2'd2,
        OFS_NONE  = 2'd3
    } reg_ofs_e;

    typedef struct packed {
        logic [HI_W-1:0] hi;
        logic [LO_W-1:0] lo;
    } eb_sel_t;

    typedef struct packed {
        logic [ADDR_W-1:0] first;
        logic [ADDR_W-1:0] last;
    } blk_range_t;

    function automatic blk_range_t blk_range(input int idx);
        int s;
        int e;
        if (idx < LO_W) begin
            s = idx * SMALL_SZ;
            e = s + SMALL_SZ - 1;
        end else if (idx == LO_W) begin
            s = MID_BASE;
            e = BIG_SZ - 1;
        end else begin
            s = (idx - LO_W) * BIG_SZ;
            e = s + BIG_SZ - 1;
        end
        return '{first: ADDR_W'(s), last: ADDR_W'(e)};
    endfunction
endpackage

// File: rtl/feb_regfile.sv
module feb_regfile
    import feb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wp_pin,
    input  logic              sw_en,
    output eb_sel_t           sel
);
    eb_sel_t cand;
    logic    hold_zero;

    assign hold_zero = wp_pin || !sw_en;

    always_comb begin
        cand = sel;
        if (wr_lo) cand.lo = wdata[LO_W-1:0];
        if (wr_hi) cand.hi = wdata[HI_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst || hold_zero) begin
            sel <= '0;
        end else if (wr_lo || wr_hi) begin
            if ($countones(cand) > 1) sel <= '0;
            else                      sel <= cand;
        end
    end

    assert_sel_onehot0_R5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(sel));
    assert_pin_clears_R3: assert property (@(posedge clk) disable iff (rst)
        wp_pin |=> (sel == '0));
    assert_swen_clears_R4: assert property (@(posedge clk) disable iff (rst)
        !sw_en |=> (sel == '0));
endmodule

// File: rtl/feb_ovl_ctl.sv
module feb_ovl_ctl
    import feb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_ovl,
    input  logic [DATA_W-1:0] wdata,
    output logic              ovl_en
);
    always_ff @(posedge clk) begin
        if (rst)         ovl_en <= 1'b0;
        else if (wr_ovl) ovl_en <= wdata[0];
    end

    assert_ovl_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !wr_ovl |=> $stable(ovl_en));
endmodule

// File: rtl/feb_decode.sv
module feb_decode
    import feb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  eb_sel_t           sel,
    input  logic              ovl_en,
    input  logic              wp_pin,
    input  logic              sw_en,
    output logic [ADDR_W-1:0] blk_start,
    output logic [ADDR_W-1:0] blk_end,
    output logic              erase_en
);
    logic [NUM_BLK-1:0] flat;
    logic               single;
    logic [ADDR_W-1:0]  s_part [NUM_BLK];
    logic [ADDR_W-1:0]  e_part [NUM_BLK];

    assign flat   = sel;
    assign single = ($countones(flat) == 1);

    for (genvar i = 0; i < NUM_BLK; i++) begin : g_blk
        localparam blk_range_t RNG = blk_range(i);
        assign s_part[i] = flat[i] ? RNG.first : '0;
        assign e_part[i] = flat[i] ? RNG.last  : '0;
    end

    always_comb begin
        blk_start = '0;
        blk_end   = '0;
        for (int i = 0; i < NUM_BLK; i++) begin
            blk_start = blk_start | s_part[i];
            blk_end   = blk_end   | e_part[i];
        end
        if (!single) begin
            blk_start = '0;
            blk_end   = '0;
        end
    end

    assign erase_en = single && sw_en && !wp_pin && !ovl_en;

    assert_erase_gate_R7: assert property (@(posedge clk) disable iff (rst)
        erase_en |-> ($onehot(flat) && !ovl_en && sw_en && !wp_pin));
    assert_range_order_R8: assert property (@(posedge clk) disable iff (rst)
        single |-> (blk_start < blk_end));
    assert_range_zero_R9: assert property (@(posedge clk) disable iff (rst)
        (flat == '0) |-> (blk_start == '0 && blk_end == '0));
endmodule

// File: rtl/flash_eblk_sel.sv
module flash_eblk_sel
    import feb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        bus_addr,
    input  logic              bus_we,
    input  logic [15:0]       bus_wdata,
    output logic [15:0]       bus_rdata,
    input  logic              wp_pin,
    input  logic              sw_en,
    output logic [11:0]       blk_sel,
    output logic [17:0]       blk_start,
    output logic [17:0]       blk_end,
    output logic              pe_protect,
    output logic              erase_en
);
    reg_ofs_e ofs;
    eb_sel_t  sel;
    logic     ovl_en;

    assign ofs = reg_ofs_e'(bus_addr);

    feb_regfile u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr_lo  (bus_we && ofs == OFS_EB_LO),
        .wr_hi  (bus_we && ofs == OFS_EB_HI),
        .wdata  (bus_wdata),
        .wp_pin (wp_pin),
        .sw_en  (sw_en),
        .sel    (sel)
    );

    feb_ovl_ctl u_ovl (
        .clk    (clk),
        .rst    (rst),
        .wr_ovl (bus_we && ofs == OFS_OVL),
        .wdata  (bus_wdata),
        .ovl_en (ovl_en)
    );

    feb_decode u_dec (
        .clk       (clk),
        .rst       (rst),
        .sel       (sel),
        .ovl_en    (ovl_en),
        .wp_pin    (wp_pin),
        .sw_en     (sw_en),
        .blk_start (blk_start),
        .blk_end   (blk_end),
        .erase_en  (erase_en)
    );

    always_comb begin
        unique case (ofs)
            OFS_EB_LO: bus_rdata = {{(DATA_W-LO_W){1'b0}}, sel.lo};
            OFS_EB_HI: bus_rdata = {{(DATA_W-HI_W){1'b0}}, sel.hi};
            OFS_OVL:   bus_rdata = {{(DATA_W-1){1'b0}}, ovl_en};
            default:   bus_rdata = '0;
        endcase
    end

    assign blk_sel    = sel;
    assign pe_protect = ovl_en;

    assert_protect_blocks_erase_R6: assert property (@(posedge clk) disable iff (rst)
        pe_protect |-> !erase_en);
endmodule

// File: tb/flash_eblk_sel_tb.sv
module flash_eblk_sel_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        wp_pin = 1'b0;
    logic        sw_en = 1'b1;
    logic [11:0] blk_sel;
    logic [17:0] blk_start;
    logic [17:0] blk_end;
    logic        pe_protect;
    logic        erase_en;

    int checks = 0;
    int failures = 0;

    logic [7:0] m_lo;
    logic [3:0] m_hi;
    logic       m_ovl;

    always #10 clk = ~clk;

    flash_eblk_sel u_dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wp_pin(wp_pin),
        .sw_en(sw_en), .blk_sel(blk_sel), .blk_start(blk_start),
        .blk_end(blk_end), .pe_protect(pe_protect), .erase_en(erase_en)
    );

    function automatic logic [17:0] exp_first(input logic [11:0] s);
        if ($countones(s) != 1) return '0;
        for (int i = 0; i < 12; i++)
            if (s[i]) begin
                if (i < 8)  return 18'(i * 32'h1000);
                if (i == 8) return 18'h08000;
                return 18'((i - 8) * 32'h10000);
            end
        return '0;
    endfunction

    function automatic logic [17:0] exp_last(input logic [11:0] s);
        if ($countones(s) != 1) return '0;
        for (int i = 0; i < 12; i++)
            if (s[i]) begin
                if (i < 8)  return 18'(i * 32'h1000 + 32'hFFF);
                if (i == 8) return 18'h0FFFF;
                return 18'((i - 8) * 32'h10000 + 32'hFFFF);
            end
        return '0;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input logic we, input logic [1:0] a, input logic [15:0] d);
        logic [11:0] c;
        bus_we = we; bus_addr = a; bus_wdata = d;
        if (wp_pin || !sw_en) begin
            m_lo = '0; m_hi = '0;
        end else if (we && (a == 2'd0 || a == 2'd1)) begin
            c = {m_hi, m_lo};
            if (a == 2'd0) c[7:0] = d[7:0];
            else           c[11:8] = d[3:0];
            if ($countones(c) > 1) c = '0;
            {m_hi, m_lo} = c;
        end
        if (we && a == 2'd2) m_ovl = d[0];
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic check_state(input string tag);
        logic [11:0] s;
        s = {m_hi, m_lo};
        bus_addr = 2'd0; #1 chk({tag, " R2 lo read"}, 32'(bus_rdata), 32'(m_lo));
        bus_addr = 2'd1; #1 chk({tag, " R2 hi read"}, 32'(bus_rdata), 32'(m_hi));
        bus_addr = 2'd2; #1 chk({tag, " R6 ovl read"}, 32'(bus_rdata), 32'(m_ovl));
        bus_addr = 2'd3; #1 chk({tag, " R10 ofs3 read"}, 32'(bus_rdata), 32'd0);
        chk({tag, " R5 blk_sel"}, 32'(blk_sel), 32'(s));
        chk({tag, " R8 start"}, 32'(blk_start), 32'(exp_first(s)));
        chk({tag, " R9 end"}, 32'(blk_end), 32'(exp_last(s)));
        chk({tag, " R6 protect"}, 32'(pe_protect), 32'(m_ovl));
        chk({tag, " R7 erase_en"}, 32'(erase_en),
            32'(($countones(s) == 1) && sw_en && !wp_pin && !m_ovl));
    endtask

    initial begin
        repeat (2000000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int dummy;
        dummy = $urandom(32'h5EED_1234);
        m_lo = '0; m_hi = '0; m_ovl = 1'b0;
        // Write junk before reset; reset must wipe it (R1)
        rst = 1'b1;
        @(negedge clk);
        bus_we = 1'b1; bus_addr = 2'd2; bus_wdata = 16'h1;
        @(negedge clk);
        bus_we = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        check_state("R1 reset");

        // R2/R8: every block individually
        for (int b = 0; b < 12; b++) begin
            if (b < 8) cyc(1'b1, 2'd1, 16'h0);
            else       cyc(1'b1, 2'd0, 16'h0);
            if (b < 8) cyc(1'b1, 2'd0, 16'(1 << b));
            else       cyc(1'b1, 2'd1, 16'(1 << (b - 8)));
            check_state("R8 single block");
        end

        // R2: reserved high bits dropped; selects block 10 only
        cyc(1'b1, 2'd0, 16'h0);
        cyc(1'b1, 2'd1, 16'hFFF4);
        check_state("R2 reserved bits");

        // R5: second bit through the other register clears all
        cyc(1'b1, 2'd0, 16'h08);
        check_state("R5 cross-register multi");
        cyc(1'b1, 2'd0, 16'h08);
        cyc(1'b1, 2'd1, 16'h1);
        check_state("R5 cross-register multi 2");
        cyc(1'b1, 2'd0, 16'h03);
        check_state("R5 same-register multi");

        // R3: pin high clears and blocks writes
        cyc(1'b1, 2'd0, 16'h20);
        wp_pin = 1'b1;
        cyc(1'b0, 2'd0, 16'h0);
        check_state("R3 pin clears");
        cyc(1'b1, 2'd0, 16'h01);
        check_state("R3 pin blocks write");
        wp_pin = 1'b0;

        // R4: software enable low, pin low
        cyc(1'b1, 2'd1, 16'h2);
        sw_en = 1'b0;
        cyc(1'b0, 2'd0, 16'h0);
        check_state("R4 swen clears");
        cyc(1'b1, 2'd1, 16'h8);
        check_state("R4 swen blocks write");
        sw_en = 1'b1;

        // R6/R7: overlay protects, unaffected by pin
        cyc(1'b1, 2'd0, 16'h04);
        cyc(1'b1, 2'd2, 16'hFFFF);
        check_state("R6 overlay on");
        wp_pin = 1'b1;
        cyc(1'b1, 2'd2, 16'h0);
        check_state("R6 overlay write under pin");
        wp_pin = 1'b0;
        cyc(1'b1, 2'd0, 16'h04);
        check_state("R7 enabled");
        cyc(1'b1, 2'd3, 16'hFFFF);
        check_state("R10 ofs3 write");

        // Random mix
        for (int n = 0; n < 400; n++) begin
            logic [15:0] d;
            wp_pin = ($urandom % 10) == 0;
            sw_en  = ($urandom % 8) != 0;
            if ($urandom % 2) d = 16'(1 << ($urandom % 8));
            else              d = 16'($urandom);
            cyc(($urandom % 4) != 0, 2'($urandom % 4), d);
            check_state("random");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule